// File: doc/BRIEF.md
# Shared Physical Register Rename and Early Reclaim Unit

This unit maps the architectural registers of several hardware thread contexts onto one shared pool of physical registers. Each rename request names a thread, two source registers and, optionally, one destination register. One cycle later the unit answers with the physical tags of the sources, a freshly allocated tag for the destination, and the tag that the destination was mapped to before. The pipeline later hands that previous tag back through the retire port once the redefining instruction commits.

Registers can also come back to the pool early. A last-use hint names a thread and an architectural register. The physical register behind it is freed at once and the map entry is marked invalid, so a later read of that register without a new write is reported as not valid instead of aliasing a register that may have been reused. A context release names an idle thread. The unit then walks that thread's map entries, one per cycle, and returns every valid mapping to the pool. While the walk runs, requests for that thread are dropped. A stall output tells the front end that the pool is empty.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset every map entry is invalid, every physical register is free, and `stall`, `idle_busy` and `rn_ack` are low.
- R2: An accepted rename raises `rn_ack` on the next cycle. `rn_tag_a`/`rn_ok_a` and `rn_tag_b`/`rn_ok_b` give the requesting thread's mapping of each source and whether it is valid. Sources see the mapping as it stood before the same request's destination write.
- R3: A rename with `rn_has_dst` set takes the lowest-numbered free physical register, returns it on `rn_tag_dst` and records it as the thread's valid mapping for `rn_dst`. `rn_tag_prev`/`rn_ok_prev` return the earlier mapping of that entry and whether it was valid.
- R4: `stall` is high exactly when no physical register is free. While it is high, a rename with a destination is ignored: no `rn_ack` and no map change. A rename without a destination is still accepted.
- R5: `ret_req` returns `ret_tag` to the pool. A register freed in a cycle cannot be allocated in that cycle, and `stall` reflects it only on the next cycle.
- R6: A hint (`hint_req`) on a valid entry frees its physical register and marks the entry invalid, so a later read gives an ok flag of 0. A hint on an invalid entry changes nothing.
- R7: A release (`idle_req`) is accepted when `idle_busy` is low. `idle_busy` is high for exactly NUM_ARCH cycles, starting the cycle after acceptance. Afterwards every entry of that thread is invalid and all its previously mapped registers are free.
- R8: From the accepting cycle until the walk ends, renames and hints for the released thread are ignored. Other threads are still served.
- R9: Map entries are private to each thread: a write by one thread does not change another thread's mapping of the same architectural register.
- R10: When a hint and a destination rename hit the same entry in the same cycle, the hinted register is freed, the new mapping stands, and `rn_ok_prev` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_req | input | 1 | Rename request |
| rn_thread | input | 3 | Requesting thread |
| rn_srca | input | 5 | First source architectural register |
| rn_srcb | input | 5 | Second source architectural register |
| rn_has_dst | input | 1 | Request writes a destination |
| rn_dst | input | 5 | Destination architectural register |
| rn_ack | output | 1 | Rename response valid |
| rn_tag_a | output | 9 | Physical tag of first source |
| rn_ok_a | output | 1 | First source mapping valid |
| rn_tag_b | output | 9 | Physical tag of second source |
| rn_ok_b | output | 1 | Second source mapping valid |
| rn_tag_dst | output | 9 | Newly allocated destination tag |
| rn_tag_prev | output | 9 | Previous destination mapping |
| rn_ok_prev | output | 1 | Previous mapping was valid |
| ret_req | input | 1 | Retire free request |
| ret_tag | input | 9 | Physical register to free on retire |
| hint_req | input | 1 | Last-use hint |
| hint_thread | input | 3 | Thread of the hinted register |
| hint_arch | input | 5 | Hinted architectural register |
| idle_req | input | 1 | Context release request |
| idle_thread | input | 3 | Thread to release |
| idle_busy | output | 1 | Release walk in progress |
| stall | output | 1 | No free physical register |

## Verification
A corrupted map entry or pool bit shows up at the next rename that touches it: a wrong tag or ok flag on the response one cycle after the request, or a `stall` value that disagrees with the number of free registers one cycle after a free or an allocation. A leaked register stays hidden until the pool drains. The bench therefore fills the pool completely and checks the exact cycle where `stall` rises and falls, and it compares every allocated tag against a lowest-free model. Release walks are checked through the length of `idle_busy`, through dropped requests for the busy thread, and through invalid reads and reused tags afterwards.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_THREADS = 8;
  localparam int DEF_ARCH    = 32;
  localparam int DEF_PHYS    = 264;

  typedef enum logic {
    WALK_IDLE,
    WALK_RUN
  } walk_state_e;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NUM_PHYS  = 264,
  parameter int NUM_FREES = 3,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               take,
  output logic [PW-1:0]                      grant_tag,
  output logic                               empty,
  input  logic [NUM_FREES-1:0]               rel_vld,
  input  logic [NUM_FREES-1:0][PW-1:0]       rel_tag
);
  localparam logic [PW:0] PHYS_LIM = (PW+1)'(NUM_PHYS);

  logic [NUM_PHYS-1:0] pool_q, pool_n;
  logic                empty_q;

  // lowest-numbered free register wins
  always_comb begin
    grant_tag = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (pool_q[i]) grant_tag = PW'(i);
    end
  end

  // frees land in the next-state vector only, so they cannot be granted
  // in the cycle they arrive
  always_comb begin
    pool_n = pool_q;
    if (take) pool_n[grant_tag] = 1'b0;
    for (int f = 0; f < NUM_FREES; f++) begin
      if (rel_vld[f] && ({1'b0, rel_tag[f]} < PHYS_LIM))
        pool_n[rel_tag[f]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pool_q  <= '1;
      empty_q <= 1'b0;
    end else begin
      pool_q  <= pool_n;
      empty_q <= ~|pool_n;
    end
  end

  assign empty = empty_q;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ENTRIES = 256,
  parameter int PW          = 9,
  parameter int NUM_RD      = 5,
  parameter int NUM_CLR     = 2,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_RD-1:0][IW-1:0]       rd_idx,
  output logic [NUM_RD-1:0]               rd_valid,
  output logic [NUM_RD-1:0][PW-1:0]       rd_tag,
  input  logic                            wr_en,
  input  logic [IW-1:0]                   wr_idx,
  input  logic [PW-1:0]                   wr_tag,
  input  logic [NUM_CLR-1:0]              clr_en,
  input  logic [NUM_CLR-1:0][IW-1:0]      clr_idx
);
  // tag storage: single write port, no reset, so it maps onto distributed RAM
  logic [PW-1:0]          tag_mem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  // valid bits: clears first, a same-cycle write wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CLR; c++) begin
        if (clr_en[c]) valid_q[clr_idx[c]] <= 1'b0;
      end
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_tag[g]   = tag_mem[rd_idx[g]];
    assign rd_valid[g] = valid_q[rd_idx[g]];
  end
endmodule

// File: rtl/rn_release_walker.sv
module rn_release_walker #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_ARCH    = 32,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int AW = $clog2(NUM_ARCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] start_tid,
  output logic          busy,
  output logic [TW-1:0] cur_tid,
  output logic [AW-1:0] cur_arch
);
  import rn_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(NUM_ARCH - 1);

  walk_state_e   state_q;
  logic [TW-1:0] tid_q;
  logic [AW-1:0] arch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      tid_q   <= '0;
      arch_q  <= '0;
    end else begin
      unique case (state_q)
        WALK_IDLE: begin
          if (start) begin
            state_q <= WALK_RUN;
            tid_q   <= start_tid;
            arch_q  <= '0;
          end
        end
        WALK_RUN: begin
          if (arch_q == LAST) begin
            state_q <= WALK_IDLE;
            arch_q  <= '0;
          end else begin
            arch_q <= arch_q + 1'b1;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == WALK_RUN);
  assign cur_tid  = tid_q;
  assign cur_arch = arch_q;
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NUM_THREADS = rn_pkg::DEF_THREADS,
  parameter int NUM_ARCH    = rn_pkg::DEF_ARCH,
  parameter int NUM_PHYS    = rn_pkg::DEF_PHYS,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rn_req,
  input  logic [TW-1:0] rn_thread,
  input  logic [AW-1:0] rn_srca,
  input  logic [AW-1:0] rn_srcb,
  input  logic          rn_has_dst,
  input  logic [AW-1:0] rn_dst,
  output logic          rn_ack,
  output logic [PW-1:0] rn_tag_a,
  output logic          rn_ok_a,
  output logic [PW-1:0] rn_tag_b,
  output logic          rn_ok_b,
  output logic [PW-1:0] rn_tag_dst,
  output logic [PW-1:0] rn_tag_prev,
  output logic          rn_ok_prev,
  input  logic          ret_req,
  input  logic [PW-1:0] ret_tag,
  input  logic          hint_req,
  input  logic [TW-1:0] hint_thread,
  input  logic [AW-1:0] hint_arch,
  input  logic          idle_req,
  input  logic [TW-1:0] idle_thread,
  output logic          idle_busy,
  output logic          stall
);
  localparam int ENTRIES = NUM_THREADS * NUM_ARCH;
  localparam int MW      = $clog2(ENTRIES);
  localparam int NUM_RD  = 5;
  localparam int NUM_CLR = 2;
  localparam int NUM_FR  = 3;
  // read port assignment
  localparam int RD_A = 0, RD_B = 1, RD_D = 2, RD_H = 3, RD_W = 4;

  function automatic logic [MW-1:0] ent(input logic [TW-1:0] t, input logic [AW-1:0] a);
    ent = MW'(MW'(t) * MW'(NUM_ARCH) + MW'(a));
  endfunction

  logic                       walk_busy;
  logic [TW-1:0]              walk_tid;
  logic [AW-1:0]              walk_arch;
  logic                       walk_start;

  logic [NUM_RD-1:0][MW-1:0]  rd_idx;
  logic [NUM_RD-1:0]          rd_valid;
  logic [NUM_RD-1:0][PW-1:0]  rd_tag;
  logic [NUM_CLR-1:0]         clr_en;
  logic [NUM_CLR-1:0][MW-1:0] clr_idx;

  logic [PW-1:0]              grant;
  logic                       pool_empty;
  logic [NUM_FR-1:0]          fr_vld;
  logic [NUM_FR-1:0][PW-1:0]  fr_tag;

  logic rn_blocked, hint_blocked;
  logic rn_accept, do_alloc, hint_hit, hint_same, walk_free;

  // a thread is frozen while its release is being accepted or walked
  always_comb begin
    rn_blocked   = (walk_busy && rn_thread == walk_tid) ||
                   (idle_req && !walk_busy && rn_thread == idle_thread);
    hint_blocked = (walk_busy && hint_thread == walk_tid) ||
                   (idle_req && !walk_busy && hint_thread == idle_thread);
  end

  assign walk_start = idle_req && !walk_busy;
  assign rn_accept  = rn_req && !rn_blocked && !(rn_has_dst && pool_empty);
  assign do_alloc   = rn_accept && rn_has_dst;
  assign hint_hit   = hint_req && !hint_blocked && rd_valid[RD_H];
  assign hint_same  = hint_hit && do_alloc &&
                      (hint_thread == rn_thread) && (hint_arch == rn_dst);
  assign walk_free  = walk_busy && rd_valid[RD_W];

  always_comb begin
    rd_idx[RD_A] = ent(rn_thread, rn_srca);
    rd_idx[RD_B] = ent(rn_thread, rn_srcb);
    rd_idx[RD_D] = ent(rn_thread, rn_dst);
    rd_idx[RD_H] = ent(hint_thread, hint_arch);
    rd_idx[RD_W] = ent(walk_tid, walk_arch);
    clr_en[0]    = hint_hit;
    clr_idx[0]   = rd_idx[RD_H];
    clr_en[1]    = walk_free;
    clr_idx[1]   = rd_idx[RD_W];
    fr_vld[0]    = ret_req;
    fr_tag[0]    = ret_tag;
    fr_vld[1]    = hint_hit;
    fr_tag[1]    = rd_tag[RD_H];
    fr_vld[2]    = walk_free;
    fr_tag[2]    = rd_tag[RD_W];
  end

  rn_map_table #(
    .NUM_ENTRIES (ENTRIES),
    .PW          (PW),
    .NUM_RD      (NUM_RD),
    .NUM_CLR     (NUM_CLR)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .wr_en    (do_alloc),
    .wr_idx   (rd_idx[RD_D]),
    .wr_tag   (grant),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx)
  );

  rn_free_pool #(
    .NUM_PHYS  (NUM_PHYS),
    .NUM_FREES (NUM_FR)
  ) u_pool (
    .clk       (clk),
    .rst       (rst),
    .take      (do_alloc),
    .grant_tag (grant),
    .empty     (pool_empty),
    .rel_vld   (fr_vld),
    .rel_tag   (fr_tag)
  );

  rn_release_walker #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_ARCH    (NUM_ARCH)
  ) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start     (walk_start),
    .start_tid (idle_thread),
    .busy      (walk_busy),
    .cur_tid   (walk_tid),
    .cur_arch  (walk_arch)
  );

  // registered rename response
  always_ff @(posedge clk) begin
    if (rst) begin
      rn_ack      <= 1'b0;
      rn_ok_a     <= 1'b0;
      rn_ok_b     <= 1'b0;
      rn_ok_prev  <= 1'b0;
      rn_tag_a    <= '0;
      rn_tag_b    <= '0;
      rn_tag_dst  <= '0;
      rn_tag_prev <= '0;
    end else begin
      rn_ack      <= rn_accept;
      rn_ok_a     <= rn_accept && rd_valid[RD_A];
      rn_ok_b     <= rn_accept && rd_valid[RD_B];
      rn_ok_prev  <= do_alloc && rd_valid[RD_D] && !hint_same;
      rn_tag_a    <= rd_tag[RD_A];
      rn_tag_b    <= rd_tag[RD_B];
      rn_tag_dst  <= grant;
      rn_tag_prev <= rd_tag[RD_D];
    end
  end

  assign idle_busy = walk_busy;
  assign stall     = pool_empty;
endmodule

// File: rtl/rn_rename_checks.sv
module rn_rename_checks #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_ARCH    = 32,
  parameter int NUM_PHYS    = 264,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input logic          clk,
  input logic          rst,
  input logic          rn_req,
  input logic [TW-1:0] rn_thread,
  input logic          rn_has_dst,
  input logic          rn_ack,
  input logic [PW-1:0] rn_tag_dst,
  input logic [PW-1:0] rn_tag_prev,
  input logic          rn_ok_prev,
  input logic          idle_req,
  input logic [TW-1:0] idle_thread,
  input logic          idle_busy,
  input logic          stall
);
  localparam logic [PW:0] PHYS_LIM = (PW+1)'(NUM_PHYS);

  int unsigned   busy_run;
  logic [TW-1:0] held_tid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run <= 0;
      held_tid <= '0;
    end else begin
      busy_run <= idle_busy ? busy_run + 1 : 0;
      if (idle_req && !idle_busy) held_tid <= idle_thread;
    end
  end

  a_r2_ack_needs_request: assert property (@(posedge clk) disable iff (rst)
    rn_ack |-> $past(rn_req));

  a_r4_no_alloc_when_empty: assert property (@(posedge clk) disable iff (rst)
    (rn_req && rn_has_dst && stall) |=> !rn_ack);

  a_r3_tag_in_range: assert property (@(posedge clk) disable iff (rst)
    rn_ack |-> ({1'b0, rn_tag_dst} < PHYS_LIM));

  a_r3_fresh_tag_differs: assert property (@(posedge clk) disable iff (rst)
    (rn_ack && rn_ok_prev) |-> (rn_tag_dst != rn_tag_prev));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (idle_req && !idle_busy) |=> idle_busy);

  a_r7_walk_bounded: assert property (@(posedge clk) disable iff (rst)
    idle_busy |-> (busy_run < NUM_ARCH));

  a_r8_walked_thread_dropped: assert property (@(posedge clk) disable iff (rst)
    (idle_busy && rn_req && rn_thread == held_tid) |=> !rn_ack);
endmodule

bind rn_rename_unit rn_rename_checks #(
  .NUM_THREADS (NUM_THREADS),
  .NUM_ARCH    (NUM_ARCH),
  .NUM_PHYS    (NUM_PHYS)
) u_rn_checks (.*);

// File: tb/test_rn_rename_unit.sv
`timescale 1ns/1ps
module test_rn_rename_unit;
  localparam int NT = 8, NA = 32, NP = 264;
  localparam int NE = NT * NA;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic       rn_req = 0, rn_has_dst = 0, ret_req = 0, hint_req = 0, idle_req = 0;
  logic [2:0] rn_thread = 0, hint_thread = 0, idle_thread = 0;
  logic [4:0] rn_srca = 0, rn_srcb = 0, rn_dst = 0, hint_arch = 0;
  logic [8:0] ret_tag = 0;
  logic       rn_ack, rn_ok_a, rn_ok_b, rn_ok_prev, idle_busy, stall;
  logic [8:0] rn_tag_a, rn_tag_b, rn_tag_dst, rn_tag_prev;

  rn_rename_unit i_rn_rename_unit (.*);

  typedef struct packed {
    logic ok_a; logic [8:0] tag_a;
    logic ok_b; logic [8:0] tag_b;
    logic has_d; logic [8:0] tag_d;
    logic ok_p; logic [8:0] tag_p;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, errors = 0, busy_seen = 0;

  // reference model state
  bit         m_valid[NE];
  logic [8:0] m_tag[NE];
  bit         m_free[NP];
  bit         m_busy = 0;
  logic [2:0] m_btid = 0;

  // staged drive values
  logic d_rq, d_hd, d_rv, d_hv, d_iv;
  logic [2:0] d_t, d_ht, d_it;
  logic [4:0] d_a, d_b, d_d, d_ha;
  logic [8:0] d_rt;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_lowest();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  function automatic bit m_blocked(input logic [2:0] t);
    return (m_busy && t == m_btid) || (d_iv && !m_busy && t == d_it);
  endfunction

  task automatic clear_d();
    d_rq = 0; d_hd = 0; d_rv = 0; d_hv = 0; d_iv = 0;
    d_t = 0; d_ht = 0; d_it = 0; d_a = 0; d_b = 0; d_d = 0; d_ha = 0; d_rt = 0;
  endtask

  // driver: predict, push expectation, apply for one cycle
  task automatic go();
    bit m_empty, acc, hhit;
    int hidx, didx, g;
    exp_t e;
    m_empty = (m_lowest() < 0);
    if (!m_busy) chk(stall == m_empty, "R4", "stall vs free count", int'(stall), int'(m_empty));
    acc  = d_rq && !m_blocked(d_t) && !(d_hd && m_empty);
    hidx = d_ht * NA + d_ha;
    didx = d_t * NA + d_d;
    hhit = d_hv && !m_blocked(d_ht) && m_valid[hidx];
    g = m_lowest();
    if (acc) begin
      e = '0;
      e.ok_a = m_valid[d_t*NA+d_a]; e.tag_a = e.ok_a ? m_tag[d_t*NA+d_a] : 9'd0;
      e.ok_b = m_valid[d_t*NA+d_b]; e.tag_b = e.ok_b ? m_tag[d_t*NA+d_b] : 9'd0;
      e.has_d = d_hd;
      if (d_hd) begin
        e.tag_d = 9'(g);
        e.ok_p  = m_valid[didx] && !(hhit && hidx == didx);
        e.tag_p = e.ok_p ? m_tag[didx] : 9'd0;
      end
      sb_q.push_back(e);
    end
    if (hhit) begin m_free[m_tag[hidx]] = 1; m_valid[hidx] = 0; end
    if (acc && d_hd) begin m_free[g] = 0; m_valid[didx] = 1; m_tag[didx] = 9'(g); end
    if (d_rv && d_rt < NP) m_free[d_rt] = 1;
    if (d_iv && !m_busy) begin m_busy = 1; m_btid = d_it; end
    rn_req = d_rq; rn_thread = d_t; rn_srca = d_a; rn_srcb = d_b;
    rn_has_dst = d_hd; rn_dst = d_d; ret_req = d_rv; ret_tag = d_rt;
    hint_req = d_hv; hint_thread = d_ht; hint_arch = d_ha;
    idle_req = d_iv; idle_thread = d_it;
    @(negedge clk);
    clear_d();
    rn_req = 0; ret_req = 0; hint_req = 0; idle_req = 0;
  endtask

  task automatic set_ren(input int t, input int a, input int b, input bit hd, input int d);
    d_rq = 1; d_t = 3'(t); d_a = 5'(a); d_b = 5'(b); d_hd = hd; d_d = 5'(d);
  endtask
  task automatic ren(input int t, input int a, input int b, input bit hd, input int d);
    set_ren(t, a, b, hd, d); go();
  endtask
  task automatic set_hint(input int t, input int a);
    d_hv = 1; d_ht = 3'(t); d_ha = 5'(a);
  endtask

  // monitor: pop and compare every response
  always @(negedge clk) begin
    if (!rst && rn_ack) begin
      exp_t got, e;
      got = '0;
      got.ok_a = rn_ok_a; got.tag_a = rn_ok_a ? rn_tag_a : 9'd0;
      got.ok_b = rn_ok_b; got.tag_b = rn_ok_b ? rn_tag_b : 9'd0;
      if (sb_q.size() == 0) begin
        chk(0, "R4/R8", "unexpected rename ack", 1, 0);
      end else begin
        e = sb_q.pop_front();
        got.has_d = e.has_d;
        if (e.has_d) begin
          got.tag_d = rn_tag_dst;
          got.ok_p = rn_ok_prev; got.tag_p = rn_ok_prev ? rn_tag_prev : 9'd0;
        end
        checks++;
        if (got != e) begin
          errors++;
          $display("FAIL R2/R3 rename response: actual=%h expected=%h", got, e);
        end
      end
    end
    if (!rst && idle_busy) busy_seen++;
  end

  initial begin : watchdog
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) m_free[i] = 1;
    for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_tag[i] = 0; end
    clear_d();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(stall == 0, "R1", "stall after reset", int'(stall), 0);
    chk(idle_busy == 0, "R1", "busy after reset", int'(idle_busy), 0);
    chk(rn_ack == 0, "R1", "ack after reset", int'(rn_ack), 0);

    // R1/R3: first write gets tag 0, sources invalid
    ren(0, 1, 2, 1, 1);
    // R2/R3: source sees tag 0, redefine returns previous tag 0
    ren(0, 1, 1, 1, 1);
    // R9: other thread's r1 still invalid
    ren(1, 1, 0, 1, 1);
    // R5: retire tag 0 and allocate in the same cycle; tag 0 not granted yet
    d_rv = 1; d_rt = 9'd0; set_ren(2, 0, 0, 1, 0); go();
    ren(2, 1, 0, 1, 1);
    // R6: hint frees t0 r1, later read reports invalid
    set_hint(0, 1); go();
    ren(0, 1, 2, 0, 0);
    ren(3, 0, 0, 1, 4);
    // R6: hint on an invalid entry has no effect
    set_hint(5, 9); go();
    ren(5, 9, 0, 1, 9);
    // R10: hint and rename to the same entry in one cycle
    set_hint(2, 0); set_ren(2, 0, 1, 1, 0); go();
    ren(2, 0, 0, 0, 0);

    // R4: fill the pool completely
    for (int i = 0; i < 400 && m_lowest() >= 0; i++) ren((i / NA) % NT, i % NA, (i + 3) % NA, 1, i % NA);
    chk(stall == 1, "R4", "stall when pool empty", int'(stall), 1);
    ren(6, 2, 3, 1, 2);                    // dropped
    ren(6, 2, 3, 0, 0);                    // accepted without destination
    // R5: free and allocate in one cycle while empty: allocation dropped
    d_rv = 1; d_rt = 9'd7; set_ren(4, 0, 1, 1, 5); go();
    chk(stall == 0, "R5", "stall cleared one cycle after free", int'(stall), 0);
    ren(4, 0, 1, 1, 5);
    chk(stall == 1, "R4", "stall after last register taken", int'(stall), 1);

    // R7/R8: release thread 3
    busy_seen = 0;
    d_iv = 1; d_it = 3'd3; set_ren(3, 0, 0, 0, 0); go();   // same-cycle rename dropped
    chk(idle_busy == 1, "R7", "busy after release accept", int'(idle_busy), 1);
    ren(3, 1, 2, 0, 0);                    // R8: dropped
    set_hint(3, 4); go();                  // R8: dropped
    ren(4, 1, 2, 0, 0);                    // R8: other thread served
    d_iv = 1; d_it = 3'd5; go();           // R7: second release ignored while busy
    for (int i = 0; i < 60 && idle_busy; i++) go();
    chk(busy_seen == NA, "R7", "busy cycle count", busy_seen, NA);
    for (int i = 0; i < NA; i++) begin
      if (m_valid[3*NA+i]) begin m_free[m_tag[3*NA+i]] = 1; m_valid[3*NA+i] = 0; end
    end
    m_busy = 0;
    chk(stall == 0, "R7", "pool refilled by release", int'(stall), 0);
    ren(3, 0, 31, 1, 4);                   // R7: invalid reads, lowest freed tag
    ren(3, 4, 5, 1, 5);
    ren(5, 9, 1, 0, 0);                    // R7: thread 5 untouched by ignored release
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R2", "pending responses", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule